// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block connects an on-chip requester to an external asynchronous static RAM of 128K words by 16 bits. The requester offers one word access at a time through a request/ready handshake. Each request carries a 17-bit word address, a read/write flag, 16 bits of write data and a two-bit lane mask, where bit 1 selects bits 15:8 and bit 0 selects bits 7:0. The controller then runs the full memory cycle on active-low strobes. A read returns its word with a one-clock valid strobe. The external data bus is modelled as a tri-state pad: a drive value, a drive enable and a sampled input.

Every analogue timing figure is a nanosecond parameter. The controller converts it to clocks as max(1, ceil(t / clock period)). With the default 4 ns clock this gives:

- read access: 18 clocks
- bus turnaround: 1 clock
- write pulse: 15 clocks
- write hold/recovery: 3 clocks (the larger of the hold count and the write-cycle count minus the pulse count)

The state machine has six named states:

- `ST_IDLE`: everything deselected.
- `ST_RD_GAP`: a one-clock deselected bubble between a write and a read.
- `ST_RD_ACC`: read access.
- `ST_WR_TURN`: the memory's output enable is high and nothing drives yet.
- `ST_WR_PULSE`: the write overlap.
- `ST_WR_HOLD`: the byte enables are high and write enable is still low.

Transitions:

- `ST_IDLE` goes to `ST_WR_TURN` when it accepts a write and to `ST_RD_ACC` when it accepts a read.
- `ST_RD_GAP` goes to `ST_RD_ACC`.
- `ST_RD_ACC` goes to `ST_IDLE` when its count ends.
- `ST_WR_TURN` goes to `ST_WR_PULSE`, and `ST_WR_PULSE` goes to `ST_WR_HOLD`.
- On the last hold clock, `ST_WR_HOLD` goes to `ST_WR_PULSE` for a chained write, to `ST_RD_GAP` for a read, and to `ST_IDLE` with no request.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, chip enable, output enable, write enable and both byte enables are high, the bus drive enable is low and ready is high.
- R2: A read keeps chip enable and output enable low, write enable high and the byte enables low for exactly the masked lanes during 18 clocks (default). Ready is low for that whole time. A read that follows a write first spends one clock fully deselected.
- R3: Read data is sampled on the last access clock and presented with a valid strobe lasting one clock. Lanes outside the mask read back as zero.
- R4: A write from idle first holds chip enable low with output enable and write enable high for the turnaround count (1 clock) before write enable falls. Output enable and write enable are never low together, and the bus is driven only while output enable is high.
- R5: The write overlap lasts the pulse count (15 clocks), with the masked byte enables and write enable low. The write ends when the byte enables rise while write enable stays low. Address and data do not change inside the overlap.
- R6: Address and data stay driven for the hold count (3 clocks) after the byte enables rise, so each write takes at least the write-cycle count.
- R7: A write request accepted on the last hold clock starts its overlap on the next clock. Write enable stays low and there is no turnaround; only the byte enables frame each word.
- R8: A write with lane mask 00 lowers no byte enable and leaves the stored word unchanged.
- R9: Each phase length is max(1, ceil(time / clock period)) of its nanosecond parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request |
| ready | output | 1 | Request accepted on this clock edge when high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wdata | input | 16 | Write data |
| bmask | input | 2 | Lane select: bit 1 upper byte, bit 0 lower byte |
| rvalid | output | 1 | Read data valid, one clock |
| rdata | output | 16 | Read data |
| sram_addr | output | 17 | Memory address bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| sram_dq_o | output | 16 | Data bus drive value |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_i | input | 16 | Data bus sampled value |

## Verification
Some properties are checked by assertions on every clock:

- output enable and write enable are never low together;
- the bus is never driven while the memory may drive it;
- write enable falls only after a turnaround clock;
- a write is always ended by the byte enables;
- address and data stay put inside an overlap;
- the valid strobe lasts one clock.

The exact phase lengths in clocks, the back-to-back write chaining, the read bubble after a write, lane masking of read data and the zero-mask write can only be shown by the bench. Its clock-by-clock model predicts every strobe and compares them, and it reads back the words held in a behavioural memory.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_GAP,
        ST_RD_ACC,
        ST_WR_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } asram_state_e;

    // Clocks needed to cover t_ns, never less than one (R9)
    function automatic int unsigned ns_to_clk(input int unsigned t_ns, input int unsigned per_ns);
        int unsigned c;
        c = (t_ns + per_ns - 1) / per_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture
    import asram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] lane_bits;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane_bits[g*8 +: 8] = {8{lanes[g]}};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= capture;
            if (capture)
                rdata <= dq_i & lane_bits;
        end
    end

    // R3: the valid strobe never lasts longer than one clock
    assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned CLK_NS    = 4,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_AA_NS   = 70,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_PWE_NS  = 60,
    parameter int unsigned T_SCE_NS  = 60,
    parameter int unsigned T_SD_NS   = 30,
    parameter int unsigned T_HD_NS   = 0,
    parameter int unsigned T_TURN_NS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    output logic              ready,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic [1:0]        bmask,
    output logic              rvalid,
    output logic [15:0]       rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic [15:0]       sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [15:0]       sram_dq_i
);
    // Phase lengths in clocks (R9)
    localparam int unsigned RD_CYC   = umax(ns_to_clk(T_RC_NS, CLK_NS), ns_to_clk(T_AA_NS, CLK_NS));
    localparam int unsigned WP_CYC   = umax(umax(ns_to_clk(T_PWE_NS, CLK_NS), ns_to_clk(T_SCE_NS, CLK_NS)),
                                            ns_to_clk(T_SD_NS, CLK_NS));
    localparam int unsigned WC_CYC   = ns_to_clk(T_WC_NS, CLK_NS);
    localparam int unsigned HOLD_CYC = umax(ns_to_clk(T_HD_NS, CLK_NS),
                                            (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1);
    localparam int unsigned TURN_CYC = ns_to_clk(T_TURN_NS, CLK_NS);
    localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WP_CYC), umax(HOLD_CYC, TURN_CYC));
    localparam int unsigned CW       = $clog2(MAX_CYC + 1);

    localparam logic [CW-1:0] RD_LD   = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WP_LD   = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);

    asram_state_e state_q, state_d;
    logic          load, last, accept;
    logic [CW-1:0] load_val;
    logic [1:0]    lanes_q, lanes_d;
    logic          capture;

    asram_phase_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    assign ready   = (state_q == ST_IDLE) || ((state_q == ST_WR_HOLD) && last);
    assign accept  = ready && req;
    assign lanes_d = accept ? bmask : lanes_q;
    assign capture = (state_q == ST_RD_ACC) && last;

    // Next-state and phase-count selection
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    load = 1'b1;
                    if (wr) begin
                        state_d  = ST_WR_TURN;
                        load_val = TURN_LD;
                    end else begin
                        state_d  = ST_RD_ACC;
                        load_val = RD_LD;
                    end
                end
            end
            ST_RD_GAP: begin
                state_d  = ST_RD_ACC;
                load     = 1'b1;
                load_val = RD_LD;
            end
            ST_RD_ACC: begin
                if (last) state_d = ST_IDLE;
            end
            ST_WR_TURN: begin
                if (last) begin
                    state_d  = ST_WR_PULSE;
                    load     = 1'b1;
                    load_val = WP_LD;
                end
            end
            ST_WR_PULSE: begin
                if (last) begin
                    state_d  = ST_WR_HOLD;
                    load     = 1'b1;
                    load_val = HOLD_LD;
                end
            end
            ST_WR_HOLD: begin
                if (last) begin
                    if (req && wr) begin
                        state_d  = ST_WR_PULSE;
                        load     = 1'b1;
                        load_val = WP_LD;
                    end else if (req) begin
                        state_d  = ST_RD_GAP;
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lanes_q   <= '0;
            sram_addr <= '0;
            sram_dq_o <= '0;
        end else begin
            state_q <= state_d;
            lanes_q <= lanes_d;
            if (accept) begin
                sram_addr <= addr;
                sram_dq_o <= wdata;
            end
        end
    end

    // Registered strobes, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n} <= 5'b11111;
            sram_dq_oe <= 1'b0;
        end else begin
            unique case (state_d)
                ST_RD_ACC: begin
                    {sram_ce_n, sram_oe_n, sram_we_n} <= 3'b001;
                    {sram_ub_n, sram_lb_n} <= ~lanes_d;
                    sram_dq_oe <= 1'b0;
                end
                ST_WR_TURN: begin
                    {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n} <= 5'b01111;
                    sram_dq_oe <= 1'b0;
                end
                ST_WR_PULSE: begin
                    {sram_ce_n, sram_oe_n, sram_we_n} <= 3'b010;
                    {sram_ub_n, sram_lb_n} <= ~lanes_d;
                    sram_dq_oe <= 1'b1;
                end
                ST_WR_HOLD: begin
                    {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n} <= 5'b01011;
                    sram_dq_oe <= 1'b1;
                end
                default: begin
                    {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n} <= 5'b11111;
                    sram_dq_oe <= 1'b0;
                end
            endcase
        end
    end

    asram_rd_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .lanes   (lanes_q),
        .dq_i    (sram_dq_i),
        .rvalid  (rvalid),
        .rdata   (rdata)
    );

    // R1: a deselected chip sees every other strobe high and an undriven bus
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce_n |-> (sram_oe_n && sram_we_n && sram_ub_n && sram_lb_n && !sram_dq_oe));

    // R2: ready stays low while the memory drives the bus
    assert_busy_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !ready);

    // R4: never read and write enable together
    assert_oe_we_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    // R4: controller drives only while the memory outputs are off
    assert_drive_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    // R4: write enable falls only after a clock with output enable high and chip selected
    assert_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($past(sram_oe_n) && !$past(sram_ce_n)));

    // R5: a write overlap is ended by the byte enables, write enable still low
    assert_be_ends_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sram_lb_n) && $past(sram_oe_n)) |-> !sram_we_n);

    // R5: address and data steady inside an overlap
    assert_overlap_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && $past(!sram_we_n) && !sram_lb_n && $past(!sram_lb_n))
            |-> ($stable(sram_dq_o) && $stable(sram_addr)));
endmodule

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;
    localparam int CLK_NS = 4;

    // Expected phase lengths from the nanosecond figures (R9)
    function automatic int cyc(input int t);
        int c;
        c = (t + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int RD   = cyc(70);
    localparam int WP   = cyc(60);
    localparam int TURN = cyc(4);
    localparam int HOLD = (cyc(70) - cyc(60) > cyc(0)) ? cyc(70) - cyc(60) : cyc(0);

    logic clk = 0, rst_n = 0;
    logic req = 0, wr = 0;
    logic [16:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  bmask = '0;
    logic ready, rvalid;
    logic [15:0] rdata;
    logic [16:0] sram_addr;
    logic sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe;
    logic [15:0] sram_dq_o;
    logic [15:0] sram_dq_i = '0;

    always #(CLK_NS/2) clk = ~clk;

    asram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr(wr),
        .addr(addr), .wdata(wdata), .bmask(bmask), .rvalid(rvalid), .rdata(rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    int n_chk = 0, n_fail = 0;

    // Behavioural external memory
    logic [15:0] mem [int];
    logic [15:0] shadow [int];

    function automatic logic [15:0] rd_arr(input int a, input bit sh);
        if (sh) return shadow.exists(a) ? shadow[a] : 16'h0000;
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        logic [15:0] w;
        if (!sram_ce_n && !sram_we_n && sram_dq_oe && !(sram_ub_n && sram_lb_n)) begin
            w = rd_arr(int'(sram_addr), 0);
            if (!sram_ub_n) w[15:8] = sram_dq_o[15:8];
            if (!sram_lb_n) w[7:0]  = sram_dq_o[7:0];
            mem[int'(sram_addr)] = w;
        end
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            w = rd_arr(int'(sram_addr), 0);
            // unselected lanes float: model as all ones
            sram_dq_i = {sram_ub_n ? 8'hFF : w[15:8], sram_lb_n ? 8'hFF : w[7:0]};
        end else begin
            sram_dq_i = 16'hFFFF;
        end
    end

    // Clock-by-clock reference model
    typedef struct {
        logic ce, oe, we, ub, lb, drv;
        logic [16:0] a;
        logic [15:0] d;
        bit rdy, cap;
        logic [15:0] capd;
        string tag;
    } exp_t;
    exp_t q[$];
    bit exp_rv = 0;
    logic [15:0] exp_rd = '0;

    function automatic exp_t mk(input logic [4:0] s, input logic drv, input logic [16:0] a,
                                input logic [15:0] d, input string tag);
        exp_t e;
        {e.ce, e.oe, e.we, e.ub, e.lb} = s;
        e.drv = drv; e.a = a; e.d = d; e.rdy = 0; e.cap = 0; e.capd = '0; e.tag = tag;
        return e;
    endfunction

    task automatic push_wr(input bit chained, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        exp_t e;
        logic [15:0] w;
        string pt;
        pt = (m == 2'b00) ? "R8" : (chained ? "R7" : "R5");
        if (!chained)
            for (int i = 0; i < TURN; i++) q.push_back(mk(5'b01111, 0, a, d, "R4"));
        for (int i = 0; i < WP; i++) q.push_back(mk({3'b010, ~m[1], ~m[0]}, 1, a, d, pt));
        for (int i = 0; i < HOLD; i++) begin
            e = mk(5'b01011, 1, a, d, "R6");
            e.rdy = (i == HOLD - 1);
            q.push_back(e);
        end
        w = rd_arr(int'(a), 1);
        if (m[1]) w[15:8] = d[15:8];
        if (m[0]) w[7:0]  = d[7:0];
        shadow[int'(a)] = w;
    endtask

    task automatic push_rd(input bit chained, input logic [16:0] a, input logic [1:0] m);
        exp_t e;
        if (chained) q.push_back(mk(5'b11111, 0, a, '0, "R2"));
        for (int i = 0; i < RD; i++) begin
            e = mk({3'b001, ~m[1], ~m[0]}, 0, a, '0, "R2");
            if (i == RD - 1) begin
                e.cap = 1;
                e.capd = rd_arr(int'(a), 1) & {{8{m[1]}}, {8{m[0]}}};
            end
            q.push_back(e);
        end
    endtask

    always @(posedge clk) begin
        bit mrdy, chained;
        if (!rst_n) begin
            q.delete();
            exp_rv = 0;
        end else begin
            mrdy = (q.size() == 0) || q[0].rdy;
            chained = (q.size() != 0);
            exp_rv = 0;
            if (q.size() != 0) begin
                if (q[0].cap) begin exp_rv = 1; exp_rd = q[0].capd; end
                void'(q.pop_front());
            end
            if (req && mrdy) begin
                if (wr) push_wr(chained, addr, wdata, bmask);
                else    push_rd(chained, addr, bmask);
            end
        end
    end

    // Per-clock comparison away from the active edge
    always @(negedge clk) begin
        exp_t e;
        logic [4:0] act;
        if (rst_n) begin
            if (q.size() == 0) begin
                e = mk(5'b11111, 0, sram_addr, '0, "R1");
                e.rdy = 1;
            end else begin
                e = q[0];
            end
            act = {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n};
            n_chk++;
            if (act !== {e.ce, e.oe, e.we, e.ub, e.lb} || sram_dq_oe !== e.drv || ready !== e.rdy
                || (act != 5'b11111 && sram_addr !== e.a) || (e.drv && sram_dq_o !== e.d)) begin
                n_fail++;
                $display("FAIL %s: strobes=%b drv=%b rdy=%b addr=%h dq=%h expected strobes=%b drv=%b rdy=%b addr=%h dq=%h",
                         e.tag, act, sram_dq_oe, ready, sram_addr, sram_dq_o,
                         {e.ce, e.oe, e.we, e.ub, e.lb}, e.drv, e.rdy, e.a, e.d);
            end
            n_chk++;
            if (rvalid !== exp_rv || (exp_rv && rdata !== exp_rd)) begin
                n_fail++;
                $display("FAIL R3: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                         rvalid, rdata, exp_rv, exp_rd);
            end
        end
    end

    task automatic issue(input bit w, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        req = 1; wr = w; addr = a; wdata = d; bmask = m;
        while (ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        req = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if ({sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe, rvalid} !== 7'b1111100) begin
            n_fail++;
            $display("FAIL R1: reset strobes=%b%b%b%b%b drv=%b rvalid=%b expected 11111 0 0",
                     sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe, rvalid);
        end
        rst_n = 1;
        repeat (2) @(negedge clk);
        issue(1, 17'h00000, 16'h1234, 2'b11);    // R4 R5 R6 full write
        issue(0, 17'h00000, 16'h0000, 2'b11);    // R2 read right after write: gap clock
        repeat (4) @(negedge clk);
        issue(1, 17'h00001, 16'h5566, 2'b11);
        repeat (2) @(negedge clk);
        issue(1, 17'h00001, 16'hAA99, 2'b10);    // upper lane only
        repeat (2) @(negedge clk);
        issue(0, 17'h00001, 16'h0000, 2'b11);    // expect AA66
        repeat (3) @(negedge clk);
        issue(1, 17'h00002, 16'hC0DE, 2'b11);    // R7 chained writes
        issue(1, 17'h00003, 16'hBEEF, 2'b01);
        issue(1, 17'h1FFFF, 16'h7E57, 2'b11);    // top address
        repeat (2) @(negedge clk);
        issue(0, 17'h00003, 16'h0000, 2'b01);    // R3 lower only, upper reads zero
        issue(0, 17'h00002, 16'h0000, 2'b10);
        issue(0, 17'h1FFFF, 16'h0000, 2'b11);
        repeat (2) @(negedge clk);
        issue(1, 17'h00002, 16'hFFFF, 2'b00);    // R8 zero-mask write
        issue(0, 17'h00002, 16'h0000, 2'b11);    // still C0DE
        repeat (40) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end
endmodule